// File: doc/BRIEF.md
# Channel Selector with Interrupt Aggregation

This block sits between an upstream master and four downstream channels. The master writes a control byte through a byte-wide register port. The low bits of that byte choose one channel and enable it, and the block drives a one-hot select strobe for the enabled channel. The pass switches are modelled by these select outputs alone.

Each downstream channel has its own active-low interrupt line. The block brings every line through a two-flop synchronizer. It combines the lines into one interrupt output in open-drain style: an output enable that pulls the shared wire low while any channel is asserting. This happens whether or not the asserting channel is the selected one. The block does not latch interrupts, so the output and the status follow the lines.

When the master reads the control byte, the synchronized interrupt state is captured into the upper nibble of the returned byte. The master can then see which channel is asserting, select it, and service the device on it.

Top module: `chan_sel_irq`

## Requirements
- R1: While reset is asserted and after its release, the control bits are 0, no select output is active, `irq_oe_o` is 0 and `rdata_o` is 0.
- R2: A write (`wr_en_i`=1) stores `wdata_i[2:0]` into the control bits at the clock edge. Bits 7:3 of the written byte have no effect on any output or on later read data.
- R3: Control bit 2 is the enable and bits 1:0 are the channel number. With enable=1, `sel_o` has exactly bit `ch` set. With enable=0, `sel_o` is 0. `sel_o` follows the control bits in the cycle after the writing edge.
- R4: `irq_oe_o` is 1 exactly when at least one `int_ni` bit, as sampled two clock edges earlier, was 0. Each line passes through a two-flop synchronizer.
- R5: An interrupt on a channel that is not selected, or while no channel is enabled, still drives `irq_oe_o` and still appears in the read status.
- R6: Read data is {pending[3:0], 1'b0, en, ch[1:0]}. Bit 4+i is 1 when channel i's synchronized line is low, and bit 3 always reads 0.
- R7: `rdata_o` is loaded at the edge where `rd_en_i`=1 and then holds its value, whatever the interrupt lines or writes do, until the next read.
- R8: Interrupts are not latched. When every line returns high, `irq_oe_o` drops after the synchronizer delay and later reads show no pending bits.
- R9: When a read and a write happen in the same cycle, the read returns the control bits from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control byte write strobe |
| rd_en_i | input | 1 | Control byte read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered at the read edge |
| int_ni | input | 4 | Per-channel interrupt lines, active low |
| sel_o | output | 4 | One-hot channel select strobes |
| irq_oe_o | output | 1 | Pull-low enable for the shared interrupt wire |

## Verification
The interrupt lines are driven through all sixteen levels. This separates a correct bit-to-channel mapping in the status nibble from a swapped or shifted one, and an OR combine from an AND. Interrupts are raised on channels that are not selected and while no channel is enabled, which would expose gating by selection. Writes with garbage in the upper bits, every channel number with enable set and cleared, and a read in the same cycle as a write test decode, field masking and read ordering. A sequence of line changes with no read between them tells a read-time capture apart from a live status path.

// File: rtl/csi_pkg.sv
package csi_pkg;
  localparam int N_CH = 4;
  localparam int CH_W = $clog2(N_CH);

  typedef struct packed {
    logic            en;
    logic [CH_W-1:0] ch;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/csi_sync.sv
module csi_sync #(
  parameter int          W      = 4,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= RST_VAL;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/csi_ctrl_regs.sv
module csi_ctrl_regs
  import csi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_CH-1:0]   pend_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PEND_LSB = DATA_W - N_CH;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word                          = '0;
    rd_word[CTRL_W-1:0]              = ctrl_q;
    rd_word[DATA_W-1 -: N_CH]        = pend_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  // snapshot taken at read edge, then held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_word;
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/csi_sel_decode.sv
module csi_sel_decode
  import csi_pkg::*;
(
  input  ctrl_t           ctrl_i,
  output logic [N_CH-1:0] sel_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_sel
    assign sel_o[c] = ctrl_i.en && (ctrl_i.ch == CH_W'(c));
  end
endmodule

// File: rtl/chan_sel_irq.sv
module chan_sel_irq
  import csi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_CH-1:0]   int_ni,
  output logic [N_CH-1:0]   sel_o,
  output logic              irq_oe_o
);
  logic [N_CH-1:0] int_sync_n;
  logic [N_CH-1:0] pend;
  ctrl_t           ctrl;

  csi_sync #(
    .W      (N_CH),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (int_ni),
    .q_o    (int_sync_n)
  );

  assign pend     = ~int_sync_n;
  assign irq_oe_o = |pend;

  csi_ctrl_regs #(
    .DATA_W (DATA_W)
  ) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .wdata_i (wdata_i),
    .pend_i  (pend),
    .ctrl_o  (ctrl),
    .rdata_o (rdata_o)
  );

  csi_sel_decode i_dec (
    .ctrl_i (ctrl),
    .sel_o  (sel_o)
  );
endmodule

// File: rtl/chan_sel_irq_chk.sv
module chan_sel_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic [3:0] int_ni,
  input logic [3:0] sel_o,
  input logic       irq_oe_o
);
  // R3
  sel_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wdata_i[2]) |=> (sel_o == 4'b0));

  // R3
  sel_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i[2]) |=> (sel_o == (4'b1 << $past(wdata_i[1:0]))));

  // R3
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(sel_o));

  // R6
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> !rdata_o[3]);

  // R7
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  // R4 (two synchronizer stages)
  irq_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&int_ni) |-> ##2 irq_oe_o);

  // R8
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&int_ni) |-> ##2 !irq_oe_o);
endmodule

bind chan_sel_irq chan_sel_irq_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .int_ni   (int_ni),
  .sel_o    (sel_o),
  .irq_oe_o (irq_oe_o)
);

// File: tb/test_chan_sel_irq.sv
module test_chan_sel_irq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic [3:0] int_ni = 4'hF;
  logic [3:0] sel_o;
  logic       irq_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  string tag = "R1";

  // behavioural reference
  logic [3:0] line_hist [$];
  int         m_en, m_ch;
  logic [7:0] m_rdata;

  always #10 clk_i = ~clk_i;

  chan_sel_irq i_chan_sel_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .int_ni   (int_ni),
    .sel_o    (sel_o),
    .irq_oe_o (irq_oe_o)
  );

  task automatic model_reset();
    line_hist = {4'hF, 4'hF};
    m_en = 0; m_ch = 0; m_rdata = 8'h00;
  endtask

  initial model_reset();
  always @(negedge rst_ni) model_reset();

  always @(posedge clk_i) begin
    if (!rst_ni) model_reset();
    else begin
      if (rd_en_i)
        m_rdata = {~line_hist[0], 1'b0, m_en[0], m_ch[1:0]};
      if (wr_en_i) begin
        m_en = int'(wdata_i[2]);
        m_ch = int'(wdata_i[1:0]);
      end
      void'(line_hist.pop_front());
      line_hist.push_back(int_ni);
    end
  end

  task automatic check(string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_on) begin
      logic [3:0] exp_sel;
      exp_sel = (m_en != 0) ? (4'b1 << m_ch) : 4'b0;
      check("sel_o",    {4'b0, sel_o},    {4'b0, exp_sel});
      check("irq_oe_o", {7'b0, irq_oe_o}, {7'b0, |(~line_hist[0])});
      check("rdata_o",  rdata_o,          m_rdata);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic wr(logic [7:0] d);
    wr_en_i = 1'b1; wdata_i = d; tick();
    wr_en_i = 1'b0; wdata_i = 8'h00;
  endtask

  task automatic rd();
    rd_en_i = 1'b1; tick();
    rd_en_i = 1'b0;
  endtask

  initial begin
    #1 cmp_on = 1'b1;
    // R1: reset state
    tag = "R1";
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    rd(); tick();

    // R2: only low three bits stored
    tag = "R2";
    wr(8'hFD); rd(); tick();
    wr(8'h78); rd(); tick();

    // R3: every channel with and without enable
    tag = "R3";
    for (int c = 0; c < 4; c++) begin
      wr(8'h04 | 8'(c)); tick();
      wr(8'h00 | 8'(c)); tick();
    end

    // R5: unselected channel interrupts
    tag = "R5";
    wr(8'h04);
    int_ni = 4'b1011; tick(3); rd(); tick();
    wr(8'h03);
    int_ni = 4'b0111; tick(3); rd(); tick();

    // R4, R6: all line levels
    tag = "R4";
    wr(8'h06);
    for (int p = 0; p < 16; p++) begin
      int_ni = 4'(p); tick(); rd(); tick(2); rd(); tick();
    end

    // R7: no read, lines move, snapshot held
    tag = "R7";
    int_ni = 4'b0101; tick(3); rd();
    int_ni = 4'b1010; tick(4);
    int_ni = 4'hF; wr(8'h01); tick(3);

    // R8: release clears output and status
    tag = "R8";
    int_ni = 4'b0000; tick(3); rd();
    int_ni = 4'b1100; tick(3); rd();
    int_ni = 4'hF; tick(); rd(); tick(3); rd(); tick();

    // R9: read and write together
    tag = "R9";
    wr(8'h05);
    rd_en_i = 1'b1; wr(8'h02); rd_en_i = 1'b0;
    tick(); rd(); tick();

    // R1: reset mid-run
    tag = "R1";
    wr(8'h07); int_ni = 4'b0110; tick(3); rd();
    rst_ni = 1'b0; tick(2);
    int_ni = 4'hF; rst_ni = 1'b1; tick(3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule